// File: doc/BRIEF.md
# PLA Crosspoint Map Reader

This controller recovers the complete link pattern of a programmable logic array that has been made testable with a one-hot column-select shift register, row-masking decoder controls and two parity cascades. It drives the array's test inputs and watches its parity and function outputs. It walks every AND-plane and OR-plane crosspoint and streams one record per crosspoint, giving the plane, the row, the column and whether a link is present. A host compares these records with the intended programming, so any number of crosspoint faults can be located in a single pass.

The AND plane is probed first. The column index is the outer loop and the row index is the inner loop. Each probe selects one column and drives exactly one AND row to 0 while every other row stays at 1. The column parity output then shows whether that row is linked into the selected product term. After that, each column is selected once more with every AND row held high. All function outputs and the OR-row parity output are captured together in one step. One record is then emitted per OR row, and the last of these records is for the extra parity row, which has no output of its own. The AND plane needs 2·NIN·NCOL probe steps and the OR plane needs NCOL, for a total of 2·NIN·NCOL + NCOL.

Top module: `pla_map_reader`

## Requirements
- R1: After reset, `recValid` and `done` are 0. `probeColSel` is all zero, both mask outputs are 1 and `probeX` is all zero.
- R2: After `start` is accepted in idle, the first 2·NIN·NCOL records have `recIsOr`=0. They are ordered with the column as the outer loop (0..NCOL-1) and the AND row as the inner loop (0..2·NIN-1).
- R3: AND row 2k is the true literal of input k, and row 2k+1 is its complement. To probe row 2k the reader drives `probeTrueMask`=0, `probeCompMask`=1 and `probeX` all ones except bit k=0. To probe row 2k+1 it drives `probeTrueMask`=1, `probeCompMask`=0 and `probeX` all zeros except bit k=1.
- R4: The link bit of an AND record is the inverse of `obsZ1` sampled during that probe (0 on `obsZ1` means a link).
- R5: While a scan runs, `probeColSel` is one-hot with the bit of the record's column set. It changes only when the column advances.
- R6: After the AND records, each column gives NOUT+1 records with `recIsOr`=1 and rows 0..NOUT in ascending order. Both masks are held at 1 throughout.
- R7: For OR rows k < NOUT, the link bit equals `obsF[k]` captured at that column's select step.
- R8: For OR row NOUT (the parity row), the link bit equals `obsZ2` XOR the parity of all `obsF` bits captured in the same step.
- R9: While `recValid` is high and `recReady` is low, the record fields stay unchanged and the scan does not advance.
- R10: `done` is high for exactly the cycle after the last record is accepted, with `recValid` low. No records are lost or added.
- R11: A `start` pulse while a scan is in progress is ignored: the record order is unchanged, and the reader does not rerun after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a full map readout (idle only) |
| done | output | 1 | One-cycle pulse when the map is complete |
| probeX | output | NIN | Primary input values driven into the array |
| probeTrueMask | output | 1 | Forces all true-literal AND rows high when 1 |
| probeCompMask | output | 1 | Forces all complement-literal AND rows high when 1 |
| probeColSel | output | NCOL | One-hot column-select register contents |
| obsZ1 | input | 1 | Parity of all product columns |
| obsZ2 | input | 1 | Parity of all OR-row outputs, extra row included |
| obsF | input | NOUT | Function outputs |
| recValid | output | 1 | Record available |
| recReady | input | 1 | Record accepted when high with recValid |
| recIsOr | output | 1 | 0 = AND-plane record, 1 = OR-plane record |
| recRow | output | ROWW | Row index of the record |
| recCol | output | COLW | Column index of the record |
| recLink | output | 1 | 1 = link present at this crosspoint |

## Verification
The array is modelled behaviourally around the reader and given four link maps. The first is a sparse irregular map, which separates the row order from the column order and the true literals from the complement literals. The second is a dense AND plane with a checkerboard OR plane, where every AND probe must read a link. The third is an empty map, where no probe may read a link. The fourth has an OR parity row that breaks the odd-column rule, as a crosspoint fault would, so the parity-row link must come from Z2 and cannot be assumed. Runs with ready held high and runs with ready stalled two cycles out of three separate correct holding from skipped or repeated records. A start pulse in the middle of a scan shows whether the reader restarts.

// File: rtl/pla_map_pkg.sv
package pla_map_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_AND_CAP,
    ST_AND_OUT,
    ST_OR_CAP,
    ST_OR_OUT,
    ST_FIN
  } mapState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic clearAll;
    logic capAnd;
    logic capOr;
    logic stepAnd;
    logic enterOr;
    logic stepOrRow;
    logic stepOrCol;
    logic finish;
  } mapStrobe_t;

  // position flags from the datapath back to the sequencer
  typedef struct packed {
    logic lastAndRow;
    logic lastCol;
    logic lastOrRow;
  } mapStatus_t;

endpackage

// File: rtl/pla_map_datapath.sv
module pla_map_datapath
  import pla_map_pkg::*;
#(
  parameter int NIN  = 3,
  parameter int NCOL = 4,
  parameter int NOUT = 2,
  parameter int ROWW = 3,
  parameter int COLW = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  mapStrobe_t       stb,
  output mapStatus_t       sts,
  output logic [NIN-1:0]   probeX,
  output logic             probeTrueMask,
  output logic             probeCompMask,
  output logic [NCOL-1:0]  probeColSel,
  input  logic             obsZ1,
  input  logic             obsZ2,
  input  logic [NOUT-1:0]  obsF,
  output logic             recIsOr,
  output logic [ROWW-1:0]  recRow,
  output logic [COLW-1:0]  recCol,
  output logic             recLink
);

  localparam int AROWS = 2 * NIN;

  logic            active;
  logic            orPhase;
  logic [ROWW-1:0] rowIdx;
  logic [ROWW-1:0] orRow;
  logic [COLW-1:0] colIdx;
  logic            andLinkQ;
  logic [NOUT:0]   orCapQ;

  assign sts.lastAndRow = (rowIdx == ROWW'(AROWS - 1));
  assign sts.lastCol    = (colIdx == COLW'(NCOL - 1));
  assign sts.lastOrRow  = (orRow == ROWW'(NOUT));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active   <= 1'b0;
      orPhase  <= 1'b0;
      rowIdx   <= '0;
      orRow    <= '0;
      colIdx   <= '0;
      andLinkQ <= 1'b0;
      orCapQ   <= '0;
    end else begin
      if (stb.clearAll) begin
        active  <= 1'b1;
        orPhase <= 1'b0;
        rowIdx  <= '0;
        orRow   <= '0;
        colIdx  <= '0;
      end
      if (stb.capAnd) andLinkQ <= ~obsZ1;
      if (stb.capOr) begin
        // parity row has no own output: recover it from the row-parity cascade
        orCapQ <= {obsZ2 ^ (^obsF), obsF};
        orRow  <= '0;
      end
      if (stb.stepAnd) begin
        if (sts.lastAndRow) begin
          rowIdx <= '0;
          colIdx <= colIdx + COLW'(1);
        end else begin
          rowIdx <= rowIdx + ROWW'(1);
        end
      end
      if (stb.enterOr) begin
        orPhase <= 1'b1;
        rowIdx  <= '0;
        colIdx  <= '0;
      end
      if (stb.stepOrRow) orRow  <= orRow + ROWW'(1);
      if (stb.stepOrCol) colIdx <= colIdx + COLW'(1);
      if (stb.finish) begin
        active  <= 1'b0;
        orPhase <= 1'b0;
        colIdx  <= '0;
        orRow   <= '0;
      end
    end
  end

  // probe pattern: a function of the registered position only
  always_comb begin
    probeX        = '0;
    probeTrueMask = 1'b1;
    probeCompMask = 1'b1;
    if (active && !orPhase) begin
      for (int k = 0; k < NIN; k++) begin
        if (rowIdx == ROWW'(2 * k)) begin
          probeTrueMask = 1'b0;
          probeX        = '1;
          probeX[k]     = 1'b0;
        end else if (rowIdx == ROWW'(2 * k + 1)) begin
          probeCompMask = 1'b0;
          probeX        = '0;
          probeX[k]     = 1'b1;
        end
      end
    end
  end

  always_comb begin
    for (int j = 0; j < NCOL; j++) begin
      probeColSel[j] = active && (colIdx == COLW'(j));
    end
  end

  always_comb begin
    logic orBit;
    orBit = 1'b0;
    for (int k = 0; k <= NOUT; k++) begin
      if (orRow == ROWW'(k)) orBit = orCapQ[k];
    end
    recIsOr = orPhase;
    recRow  = orPhase ? orRow : rowIdx;
    recCol  = colIdx;
    recLink = orPhase ? orBit : andLinkQ;
  end

endmodule

// File: rtl/pla_map_ctrl.sv
module pla_map_ctrl
  import pla_map_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       recReady,
  input  mapStatus_t sts,
  output mapStrobe_t stb,
  output logic       recValid,
  output logic       done
);

  mapState_t state;
  mapState_t stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stb       = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          stb.clearAll = 1'b1;
          stateNext    = ST_AND_CAP;
        end
      end
      ST_AND_CAP: begin
        stb.capAnd = 1'b1;
        stateNext  = ST_AND_OUT;
      end
      ST_AND_OUT: begin
        if (recReady) begin
          if (sts.lastAndRow && sts.lastCol) begin
            stb.enterOr = 1'b1;
            stateNext   = ST_OR_CAP;
          end else begin
            stb.stepAnd = 1'b1;
            stateNext   = ST_AND_CAP;
          end
        end
      end
      ST_OR_CAP: begin
        stb.capOr = 1'b1;
        stateNext = ST_OR_OUT;
      end
      ST_OR_OUT: begin
        if (recReady) begin
          if (!sts.lastOrRow) begin
            stb.stepOrRow = 1'b1;
          end else if (sts.lastCol) begin
            stb.finish = 1'b1;
            stateNext  = ST_FIN;
          end else begin
            stb.stepOrCol = 1'b1;
            stateNext     = ST_OR_CAP;
          end
        end
      end
      ST_FIN:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  assign recValid = (state == ST_AND_OUT) || (state == ST_OR_OUT);
  assign done     = (state == ST_FIN);

endmodule

// File: rtl/pla_map_reader.sv
module pla_map_reader
  import pla_map_pkg::*;
#(
  parameter int  NIN   = 3,
  parameter int  NCOL  = 4,
  parameter int  NOUT  = 2,
  localparam int AROWS = 2 * NIN,
  localparam int ROWW  = (AROWS > NOUT + 1) ? $clog2(AROWS) : $clog2(NOUT + 1),
  localparam int COLW  = (NCOL > 1) ? $clog2(NCOL) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  output logic             done,
  output logic [NIN-1:0]   probeX,
  output logic             probeTrueMask,
  output logic             probeCompMask,
  output logic [NCOL-1:0]  probeColSel,
  input  logic             obsZ1,
  input  logic             obsZ2,
  input  logic [NOUT-1:0]  obsF,
  output logic             recValid,
  input  logic             recReady,
  output logic             recIsOr,
  output logic [ROWW-1:0]  recRow,
  output logic [COLW-1:0]  recCol,
  output logic             recLink
);

  mapStrobe_t stb;
  mapStatus_t sts;

  pla_map_ctrl ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .recReady (recReady),
    .sts      (sts),
    .stb      (stb),
    .recValid (recValid),
    .done     (done)
  );

  pla_map_datapath #(
    .NIN  (NIN),
    .NCOL (NCOL),
    .NOUT (NOUT),
    .ROWW (ROWW),
    .COLW (COLW)
  ) dp (
    .clk           (clk),
    .rstN          (rstN),
    .stb           (stb),
    .sts           (sts),
    .probeX        (probeX),
    .probeTrueMask (probeTrueMask),
    .probeCompMask (probeCompMask),
    .probeColSel   (probeColSel),
    .obsZ1         (obsZ1),
    .obsZ2         (obsZ2),
    .obsF          (obsF),
    .recIsOr       (recIsOr),
    .recRow        (recRow),
    .recCol        (recCol),
    .recLink       (recLink)
  );

endmodule

// File: rtl/pla_map_reader_chk.sv
module pla_map_reader_chk #(
  parameter int NIN  = 3,
  parameter int NCOL = 4,
  parameter int NOUT = 2,
  parameter int ROWW = 3,
  parameter int COLW = 2
) (
  input logic            clk,
  input logic            rstN,
  input logic            done,
  input logic [NIN-1:0]  probeX,
  input logic            probeTrueMask,
  input logic            probeCompMask,
  input logic [NCOL-1:0] probeColSel,
  input logic            recValid,
  input logic            recReady,
  input logic            recIsOr,
  input logic [ROWW-1:0] recRow,
  input logic [COLW-1:0] recCol,
  input logic            recLink
);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    recValid && !recReady |=> recValid && $stable(recRow) && $stable(recCol)
                              && $stable(recIsOr) && $stable(recLink));

  assert_colsel_onehot_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(probeColSel));

  assert_and_one_mask_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    recValid && !recIsOr |-> (probeTrueMask != probeCompMask)
                             && ($countones(probeColSel) == 1));

  assert_and_row_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    recValid && !recIsOr |-> (int'(recRow) < 2 * NIN));

  assert_or_masks_high_R6: assert property (@(posedge clk) disable iff (!rstN)
    recValid && recIsOr |-> probeTrueMask && probeCompMask
                            && (probeX == '0) && (int'(recRow) <= NOUT));

  assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !recValid && (probeColSel == '0));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

bind pla_map_reader pla_map_reader_chk #(
  .NIN  (NIN),
  .NCOL (NCOL),
  .NOUT (NOUT),
  .ROWW (ROWW),
  .COLW (COLW)
) chkInst (
  .clk           (clk),
  .rstN          (rstN),
  .done          (done),
  .probeX        (probeX),
  .probeTrueMask (probeTrueMask),
  .probeCompMask (probeCompMask),
  .probeColSel   (probeColSel),
  .recValid      (recValid),
  .recReady      (recReady),
  .recIsOr       (recIsOr),
  .recRow        (recRow),
  .recCol        (recCol),
  .recLink       (recLink)
);

// File: tb/pla_map_reader_test.sv
module pla_map_reader_test;

  localparam int NIN   = 3;
  localparam int NCOL  = 4;
  localparam int NOUT  = 2;
  localparam int AROWS = 2 * NIN;
  localparam int ROWW  = 3;
  localparam int COLW  = 2;
  localparam int NAND  = AROWS * NCOL;
  localparam int NREC  = NAND + NCOL * (NOUT + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic done;
  logic [NIN-1:0] probeX;
  logic probeTrueMask, probeCompMask;
  logic [NCOL-1:0] probeColSel;
  logic obsZ1, obsZ2;
  logic [NOUT-1:0] obsF;
  logic recValid;
  logic recReady = 1'b0;
  logic recIsOr;
  logic [ROWW-1:0] recRow;
  logic [COLW-1:0] recCol;
  logic recLink;

  int total = 0;
  int bad = 0;

  // link maps of the array under test; OR row NOUT is the parity row
  logic [NCOL-1:0] andLink [AROWS];
  logic [NCOL-1:0] orLink  [NOUT+1];

  always #5 clk = ~clk;

  pla_map_reader #(.NIN(NIN), .NCOL(NCOL), .NOUT(NOUT)) uut (
    .clk(clk), .rstN(rstN), .start(start), .done(done),
    .probeX(probeX), .probeTrueMask(probeTrueMask), .probeCompMask(probeCompMask),
    .probeColSel(probeColSel), .obsZ1(obsZ1), .obsZ2(obsZ2), .obsF(obsF),
    .recValid(recValid), .recReady(recReady), .recIsOr(recIsOr),
    .recRow(recRow), .recCol(recCol), .recLink(recLink)
  );

  // behavioural array with decoders and both parity cascades
  always_comb begin
    logic [AROWS-1:0] rowVal;
    logic [NCOL-1:0] prod;
    logic extraOut;
    for (int k = 0; k < NIN; k++) begin
      rowVal[2*k]   = probeX[k] | probeTrueMask;
      rowVal[2*k+1] = ~probeX[k] | probeCompMask;
    end
    for (int j = 0; j < NCOL; j++) begin
      prod[j] = probeColSel[j];
      for (int r = 0; r < AROWS; r++)
        if (andLink[r][j] && !rowVal[r]) prod[j] = 1'b0;
    end
    obsZ1 = ^prod;
    for (int k = 0; k < NOUT; k++) obsF[k] = |(prod & orLink[k]);
    extraOut = |(prod & orLink[NOUT]);
    obsZ2 = (^obsF) ^ extraOut;
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setMaps(input int pat);
    for (int r = 0; r < AROWS; r++)
      for (int j = 0; j < NCOL; j++)
        case (pat)
          0: andLink[r][j] = (((r * 3 + j * 5) % 4) == 0) || (r == j + 1);
          1: andLink[r][j] = 1'b1;
          default: andLink[r][j] = 1'b0;
        endcase
    for (int k = 0; k < NOUT; k++)
      for (int j = 0; j < NCOL; j++)
        case (pat)
          0: orLink[k][j] = ((k + 2 * j) % 3) == 0;
          1: orLink[k][j] = ((k + j) % 2) == 0;
          2: orLink[k][j] = 1'b0;
          default: orLink[k][j] = (j % 2) == 1;
        endcase
    for (int j = 0; j < NCOL; j++) begin
      logic par;
      par = 1'b0;
      for (int k = 0; k < NOUT; k++) par ^= orLink[k][j];
      // odd column parity when healthy; pattern 3 breaks it like a crosspoint fault
      orLink[NOUT][j] = (pat == 3) ? par : ~par;
    end
  endtask

  task automatic resetCheck();
    check("R1 recValid", int'(recValid), 0);
    check("R1 done", int'(done), 0);
    check("R1 colSel", int'(probeColSel), 0);
    check("R1 masks", int'({probeTrueMask, probeCompMask}), 3);
    check("R1 probeX", int'(probeX), 0);
  endtask

  task automatic checkRecord(input int idx);
    int eCol, eRow, eLink, eOr;
    if (idx < NAND) begin
      eOr = 0; eCol = idx / AROWS; eRow = idx % AROWS;
      eLink = int'(andLink[eRow][eCol]);
    end else begin
      eOr = 1; eCol = (idx - NAND) / (NOUT + 1); eRow = (idx - NAND) % (NOUT + 1);
      eLink = int'(orLink[eRow][eCol]);
    end
    check("R2/R6 plane", int'(recIsOr), eOr);
    check("R2/R6 row", int'(recRow), eRow);
    check("R2/R6 col", int'(recCol), eCol);
    check("R5 colSel", int'(probeColSel), 1 << eCol);
    if (eOr == 0) begin
      int k;
      k = eRow / 2;
      check("R4 and link", int'(recLink), eLink);
      if (eRow % 2 == 0) begin
        check("R3 masks", int'({probeTrueMask, probeCompMask}), 1);
        check("R3 probeX", int'(probeX), ((1 << NIN) - 1) & ~(1 << k));
      end else begin
        check("R3 masks", int'({probeTrueMask, probeCompMask}), 2);
        check("R3 probeX", int'(probeX), 1 << k);
      end
    end else if (eRow < NOUT) begin
      check("R7 or link", int'(recLink), eLink);
      check("R6 masks", int'({probeTrueMask, probeCompMask}), 3);
    end else begin
      check("R8 parity row link", int'(recLink), eLink);
    end
  endtask

  // stallMode 1: ready high one cycle in three (R9); pokeStart: start mid-scan (R11)
  task automatic runScan(input int pat, input int stallMode, input bit pokeStart);
    int expIdx;
    bit prevAcc, doneSeen;
    setMaps(pat);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    expIdx = 0; prevAcc = 0; doneSeen = 0;
    for (int cyc = 0; cyc < 2000 && !doneSeen; cyc++) begin
      if (prevAcc) expIdx++;
      recReady = 1'b0;
      start = 1'b0;
      if (done) begin
        check("R10 count at done", expIdx, NREC);
        check("R10 recValid at done", int'(recValid), 0);
        doneSeen = 1;
      end else if (recValid) begin
        if (expIdx >= NREC) check("R10 extra record", expIdx, NREC - 1);
        else checkRecord(expIdx);
        recReady = (stallMode == 0) ? 1'b1 : ((cyc % 3) == 0);
        if (pokeStart && expIdx == 5) start = 1'b1;
      end else if (prevAcc && expIdx == NREC) begin
        check("R10 done after last accept", int'(done), 1);
      end
      prevAcc = recValid && recReady;
      @(negedge clk);
    end
    recReady = 1'b0;
    start = 1'b0;
    if (!doneSeen) check("R10 done never seen", 0, 1);
    if (pokeStart) begin
      for (int i = 0; i < 6; i++) begin
        check("R11 no rerun", int'(recValid), 0);
        @(negedge clk);
      end
    end
    check("R1 quiet after scan", int'(probeColSel), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R10 actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    setMaps(0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    resetCheck();
    runScan(0, 0, 1'b0);
    runScan(1, 1, 1'b0);
    runScan(2, 0, 1'b1);
    runScan(3, 1, 1'b0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule